// File: doc/BRIEF.md
# Clock-Buffer Configuration Serial Slave

This block is the configuration port of a clock-buffer device. It sits on an open-drain I2C pair: SCL and SDA come in as plain inputs, and the block pulls SDA low through a single enable. The block answers one fixed 7-bit address, 0x69. It accepts only block transfers. Every block starts at register 0 and moves upward one register per byte. The register contents leave the block as a flat vector. The clock outputs use these bits as output-pair enables and as a drive-strength select. Register 6 holds four pair enables in bits 0 to 3 and the stronger-drive select in bit 5.

A write block carries the address byte 0xD2, then a command byte, then a byte-count byte. The slave acknowledges the command and byte-count bytes and then throws their values away. The data bytes that follow fill registers 0, 1, 2 and onward. A read block uses the address byte 0xD3. The slave first returns the byte count, fixed at 0x09, and then the registers in ascending order. The master ends the read by withholding its acknowledge.

Both lines pass through a two-flop synchronizer and an edge detector, so the system clock must run far faster than SCL. The controller has five states, and the transitions between them are named here:

- **ST_IDLE**: the bus is ignored. A START moves to ST_RX.
- **ST_RX**: the slave shifts in 8 bits. On the falling SCL edge after bit 8 it goes to ST_ACK_TX, or back to ST_IDLE when the address does not match.
- **ST_ACK_TX**: the slave holds SDA low for the acknowledge bit. On the next SCL fall it goes to ST_TX if this was a read-address acknowledge, and to ST_RX in every other case.
- **ST_TX**: the slave sends 8 bits, most significant bit first. After the eighth SCL fall it goes to ST_ACK_RX.
- **ST_ACK_RX**: the slave samples the master's acknowledge. On the SCL fall it goes to ST_TX if the master acknowledged and to ST_IDLE if it did not.

A STOP in any state leads to ST_IDLE. A START in any state, repeated start included, leads to ST_RX in the address phase with the register index cleared.

Top module: `clkbuf_cfg_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper 7 bits equal 1101001, so 0xD2 for write and 0xD3 for read. For any other address it leaves SDA released and ignores the bus until the next START.
- R2: In a write block the slave acknowledges the command byte and the byte-count byte and discards both. Each following data byte is acknowledged and stored in register 0, 1, 2 and so on, in order.
- R3: Write data bytes past register 8 are acknowledged and change no register.
- R4: A read block returns 0x09 as its first byte, then registers 0 to 8 in order, then 0x00 for every further byte. Each byte is sent most significant bit first.
- R5: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing until the next START.
- R6: After reset, register 6 holds 0x8F and all other registers hold 0x00. Register i appears on cfg_regs_o[8i+7:8i].
- R7: A START, repeated start included, restarts the byte sequence at the address phase with the index at register 0. A STOP returns the slave to idle.
- R8: The slave changes its SDA pull-low enable only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pull_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_regs_o | output | 72 | Register bank, register i at bits 8i+7:8i |

## Verification
Two events can share one system-clock cycle. The first is the commit of a write data byte, together with the start of its acknowledge, on the SCL fall after bit 8. The second is the turn from the read-address acknowledge into the first transmitted bit, where the release of SDA and the drive of the count byte's MSB happen in the same cycle. The bench reaches both with random block lengths, seeded by a fixed value, and with a repeated start placed mid-block. Register contents are judged against a bench-side model of the bank, read back over the bus. A line monitor checks that no change of the pull-low enable falls inside an SCL-high window.

// File: rtl/clkbuf_cfg_pkg.sv
package clkbuf_cfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK_TX,
        ST_TX,
        ST_ACK_RX
    } bus_state_t;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_CMD,
        PH_COUNT,
        PH_DATA
    } rx_phase_t;

    function automatic logic [7:0] reg_default(input int idx);
        return (idx == 6) ? 8'h8F : 8'h00;
    endfunction

endpackage

// File: rtl/bus_line_sampler.sv
module bus_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int NUM_LINES = 2;

    logic [NUM_LINES-1:0] raw;
    logic [NUM_LINES-1:0] synced;
    logic [NUM_LINES-1:0] last_q;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic [SYNC_STAGES-1:0] pipe_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '1;
            else        pipe_q <= {pipe_q[SYNC_STAGES-2:0], raw[g]};
        end
        assign synced[g] = pipe_q[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= '1;
        else        last_q <= synced;
    end

    assign scl_o      = synced[0];
    assign sda_o      = synced[1];
    assign scl_rise_o = synced[0] & ~last_q[0];
    assign scl_fall_o = ~synced[0] & last_q[0];
    assign start_o    = synced[0] & last_q[0] & ~synced[1] & last_q[1];
    assign stop_o     = synced[0] & last_q[0] & synced[1] & ~last_q[1];

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import clkbuf_cfg_pkg::*;
#(
    parameter int NUM_REGS = 9,
    parameter int IDX_W    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] regs_o
);
    logic [7:0] bank_q [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bank_q[i] <= reg_default(i);
            else if (wr_en && (wr_idx == IDX_W'(i)))
                bank_q[i] <= wr_data;
        end
        assign regs_o[8*i +: 8] = bank_q[i];
    end

    always_comb begin
        rd_data = 8'h00;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (rd_idx == IDX_W'(k)) rd_data = bank_q[k];
        end
    end

    // Out-of-range writes must never be requested (R3)
    assert_write_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < NUM_REGS));

    // A requested write lands in the addressed byte (R2)
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (regs_o[8*int'($past(wr_idx)) +: 8] == $past(wr_data)));

endmodule

// File: rtl/clkbuf_cfg_slave.sv
module clkbuf_cfg_slave
    import clkbuf_cfg_pkg::*;
#(
    parameter int         NUM_REGS    = 9,
    parameter logic [6:0] SLAVE_ADDR  = 7'b1101001,
    parameter logic [7:0] COUNT_VALUE = 8'h09
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_pull_low_o,
    output logic [NUM_REGS*8-1:0] cfg_regs_o
);
    localparam int IDX_W = $clog2(NUM_REGS + 1);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(NUM_REGS);

    logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;

    bus_state_t       state_q;
    rx_phase_t        phase_q;
    logic             rw_q;
    logic             acked_q;
    logic [3:0]       bit_cnt_q;
    logic [7:0]       shift_q;
    logic [IDX_W-1:0] idx_q;

    logic             wr_en;
    logic [7:0]       rd_data;
    logic             byte_done;

    bus_line_sampler #(.SYNC_STAGES(2)) u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_c),
        .stop_o     (stop_c)
    );

    assign byte_done = (state_q == ST_RX) && scl_fall && (bit_cnt_q == 4'd8)
                       && !start_c && !stop_c;
    assign wr_en     = byte_done && (phase_q == PH_DATA) && (idx_q != IDX_END);

    cfg_reg_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (idx_q),
        .wr_data (shift_q),
        .rd_idx  (idx_q),
        .rd_data (rd_data),
        .regs_o  (cfg_regs_o)
    );

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            phase_q   <= PH_ADDR;
            rw_q      <= 1'b0;
            acked_q   <= 1'b0;
            bit_cnt_q <= 4'd0;
            shift_q   <= 8'h00;
            idx_q     <= '0;
        end else if (stop_c) begin
            state_q <= ST_IDLE;
        end else if (start_c) begin
            state_q   <= ST_RX;
            phase_q   <= PH_ADDR;
            bit_cnt_q <= 4'd0;
            idx_q     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_RX: begin
                    if (scl_rise && bit_cnt_q != 4'd8) begin
                        shift_q   <= {shift_q[6:0], sda_s};
                        bit_cnt_q <= bit_cnt_q + 4'd1;
                    end else if (byte_done) begin
                        if (phase_q == PH_ADDR) begin
                            if (shift_q[7:1] == SLAVE_ADDR) begin
                                rw_q    <= shift_q[0];
                                state_q <= ST_ACK_TX;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end else begin
                            state_q <= ST_ACK_TX;
                        end
                    end
                end
                ST_ACK_TX: begin
                    if (scl_fall) begin
                        bit_cnt_q <= 4'd0;
                        if (phase_q == PH_ADDR && rw_q) begin
                            state_q <= ST_TX;
                            shift_q <= COUNT_VALUE;
                            phase_q <= PH_DATA;
                        end else begin
                            state_q <= ST_RX;
                            if (phase_q == PH_DATA && idx_q != IDX_END)
                                idx_q <= idx_q + 1'b1;
                            unique case (phase_q)
                                PH_ADDR:  phase_q <= PH_CMD;
                                PH_CMD:   phase_q <= PH_COUNT;
                                PH_COUNT: phase_q <= PH_DATA;
                                PH_DATA:  phase_q <= PH_DATA;
                                default:  phase_q <= PH_DATA;
                            endcase
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bit_cnt_q == 4'd7) begin
                            state_q <= ST_ACK_RX;
                            acked_q <= 1'b0;
                        end else begin
                            shift_q   <= {shift_q[6:0], 1'b0};
                            bit_cnt_q <= bit_cnt_q + 4'd1;
                        end
                    end
                end
                ST_ACK_RX: begin
                    if (scl_rise) begin
                        acked_q <= ~sda_s;
                    end else if (scl_fall) begin
                        if (acked_q) begin
                            state_q   <= ST_TX;
                            shift_q   <= rd_data;
                            bit_cnt_q <= 4'd0;
                            if (idx_q != IDX_END) idx_q <= idx_q + 1'b1;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output process
    always_comb begin
        unique case (state_q)
            ST_ACK_TX: sda_pull_low_o = 1'b1;
            ST_TX:     sda_pull_low_o = ~shift_q[7];
            default:   sda_pull_low_o = 1'b0;
        endcase
    end

    // SDA may move only while the sampled SCL is low (R8)
    assert_sda_moves_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_low_o) |-> !scl_s);

    // Transmission only follows a read address (R4)
    assert_tx_only_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TX) |-> rw_q);

    // Mismatched address leaves SDA released (R1)
    assert_addr_mismatch_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && phase_q == PH_ADDR && shift_q[7:1] != SLAVE_ADDR) |=> !sda_pull_low_o);

    // Master not-acknowledge ends the read (R5)
    assert_nack_goes_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACK_RX && scl_fall && !acked_q && !start_c && !stop_c)
        |=> (state_q == ST_IDLE));

endmodule

// File: tb/clkbuf_cfg_slave_bench.sv
module clkbuf_cfg_slave_bench;
    localparam int NREG = 9;
    localparam int Q    = 15;   // quarter SCL period in system clocks

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull_low;
    logic sda_line;
    logic [NREG*8-1:0] cfg_regs;

    int n_cmp = 0;
    int n_bad = 0;
    int r8_viol = 0;
    logic [7:0] model [NREG];

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull_low;

    clkbuf_cfg_slave u_clkbuf_cfg_slave (
        .clk            (clk),
        .rst_n          (rst_n),
        .scl_i          (scl_m),
        .sda_i          (sda_line),
        .sda_pull_low_o (sda_pull_low),
        .cfg_regs_o     (cfg_regs)
    );

    // R8 line monitor
    logic prev_drive = 1'b0;
    always @(negedge clk) begin
        if (rst_n && (sda_pull_low !== prev_drive) && scl_m) r8_viol++;
        prev_drive = sda_pull_low;
    end

    function automatic logic [7:0] dflt(input int i);
        return (i == 6) ? 8'h8F : 8'h00;
    endfunction

    function automatic logic [7:0] exp_read(input int k);
        return (k < NREG) ? model[k] : 8'h00;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1);
        sda_m = 1'b0; wq(1); scl_m = 1'b0; wq(1);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wq(1); scl_m = 1'b1; wq(1);
        sda_m = 1'b1; wq(1);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(1);
            scl_m = 1'b1; wq(2);
            scl_m = 1'b0; wq(1);
        end
        sda_m = 1'b1; wq(1);
        scl_m = 1'b1; wq(1);
        ack = ~sda_line; wq(1);
        scl_m = 1'b0; wq(1);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(1); scl_m = 1'b1; wq(1);
            b[i] = sda_line; wq(1);
            scl_m = 1'b0;
        end
        wq(1);
        sda_m = ~mack; wq(1);
        scl_m = 1'b1; wq(2);
        scl_m = 1'b0; wq(1);
        sda_m = 1'b1;
    endtask

    task automatic check_regs(input string tag);
        for (int i = 0; i < NREG; i++) chk(tag, {24'h0, cfg_regs[8*i +: 8]}, {24'h0, model[i]});
    endtask

    task automatic write_block(input int n);
        logic a;
        logic [7:0] d;
        bus_start;
        send_byte(8'hD2, a);                 chk("R1 write addr ack", a, 1);
        send_byte(8'($urandom), a);          chk("R2 cmd ack", a, 1);
        send_byte(8'($urandom), a);          chk("R2 count ack", a, 1);
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            send_byte(d, a);
            chk(k < NREG ? "R2 data ack" : "R3 extra data ack", a, 1);
            if (k < NREG) model[k] = d;
        end
        bus_stop;
        check_regs("R2/R3 bank after write");
    endtask

    task automatic read_block(input int n);
        logic a;
        logic [7:0] d;
        bus_start;
        send_byte(8'hD3, a);                 chk("R1 read addr ack", a, 1);
        recv_byte(n > 0, d);                 chk("R4 count byte", d, 8'h09);
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, d);
            chk("R4 read data", d, exp_read(k));
        end
        recv_byte(1'b1, d);                  chk("R5 released after nack", d, 8'hFF);
        bus_stop;
    endtask

    initial begin
        logic a;
        logic [7:0] d;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < NREG; i++) model[i] = dflt(i);
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        chk("R6 reset drive", sda_pull_low, 0);
        check_regs("R6 reset bank");
        read_block(11);

        write_block(11);
        read_block(11);

        // Wrong address: not acknowledged, following bytes ignored (R1)
        bus_start;
        send_byte(8'hA4, a);                 chk("R1 wrong addr nack", a, 0);
        send_byte(8'h00, a);                 chk("R1 ignored after mismatch", a, 0);
        send_byte(8'h55, a);                 chk("R1 ignored after mismatch", a, 0);
        bus_stop;
        check_regs("R1 bank untouched");

        // Early nack after two data bytes (R5)
        read_block(2);

        // Repeated start mid write, then read restarts at count (R7)
        bus_start;
        send_byte(8'hD2, a);                 chk("R7 addr ack", a, 1);
        send_byte(8'h11, a);                 chk("R7 cmd ack", a, 1);
        bus_start;
        send_byte(8'hD3, a);                 chk("R7 read after rstart", a, 1);
        recv_byte(1'b1, d);                  chk("R7 count after rstart", d, 8'h09);
        recv_byte(1'b0, d);                  chk("R7 index back at 0", d, model[0]);
        bus_stop;

        // Repeated start mid write data: new block restarts at register 0 (R7)
        bus_start;
        send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h09, a);
        send_byte(8'h3C, a); model[0] = 8'h3C;
        send_byte(8'hC3, a); model[1] = 8'hC3;
        bus_start;
        send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h09, a);
        send_byte(8'h7E, a); model[0] = 8'h7E;
        bus_stop;
        check_regs("R7 restart at reg 0");

        for (int r = 0; r < 4; r++) begin
            write_block(1 + int'($urandom % 11));
            read_block(1 + int'($urandom % 11));
        end

        chk("R8 SDA change only while SCL low", r8_viol, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule